// File: doc/BRIEF.md
# VBI Caption and Wide-Screen Payload Line Inserter

This block decides which two-byte payloads are sent on the vertical-blanking lines of a video frame. Software writes caption byte pairs and wide-screen signalling byte pairs through a small register write port. The video timing logic tells the block when each line starts, which line it is, and which field it belongs to. On the caption line and on the wide-screen line, the block puts out one valid pulse that carries the two bytes a downstream modulator should place on that line. It also flags which service the bytes belong to.

Each byte pair only becomes live when its second byte is written. A first-byte write on its own only loads a staging register. The two services keep their payloads differently. The wide-screen payload is kept and sent again every frame until it is replaced. A caption payload is sent once only; on later caption lines the block sends the caption null pair until fresh data is committed. A control register holds one enable bit per service.

Top module: `vbi_line_inserter`

## Requirements
- R1: After reset, outValid is 0, both services are disabled, the committed wide-screen pair is 0x00,0x00, and no fresh caption pair is pending.
- R2: The register map is: address 0 is control (bit 0 caption enable, bit 1 wide-screen enable); address 1 is caption first byte; address 2 is caption second byte; address 3 is wide-screen first byte; address 4 is wide-screen second byte. Byte 0 of the output is the first byte and byte 1 is the second byte.
- R3: If lineStart is high with lineNum equal to CAP_LINE (default 21) and fieldId equal to 0 while captions are enabled, outValid is 1 on the next cycle only. In that cycle outService is 0 and the bytes are the pair committed since the previous caption emission.
- R4: On an enabled caption line with no commit since the previous caption emission, the bytes are the null pair 0x80,0x80.
- R5: If lineStart is high with lineNum equal to WSS_LINE (default 23) and fieldId equal to 0 while wide-screen is enabled, outValid is 1 on the next cycle with outService 1 and the last committed wide-screen pair. The same pair repeats every frame until a new pair is committed.
- R6: Writing only the first byte of a pair does not change the pair that is sent. A later second-byte write commits the most recently written first byte.
- R7: A second-byte write in the same cycle as the lineStart of that service's line, or later in that line, does not change the bytes sent on that line. It takes effect on the next frame's line.
- R8: A disabled service produces no outValid on its line. A pending caption pair is not consumed while captions are disabled.
- R9: lineStart on any other line number, or with fieldId 1, produces no outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 8 | Register write data |
| lineStart | input | 1 | One-cycle pulse at the start of each video line |
| lineNum | input | LINE_W | Number of the line that is starting |
| fieldId | input | 1 | Field of the line that is starting (0 = first) |
| outValid | output | 1 | One-cycle pulse: payload for this line is valid |
| outService | output | 1 | 0 = caption pair, 1 = wide-screen pair |
| outByte0 | output | 8 | First payload byte |
| outByte1 | output | 8 | Second payload byte |

## Verification
The caption freshness flag is the state most likely to go wrong, and it can only be seen at a caption line. If it is stuck set, the second caption line after a commit repeats the old pair where the null pair is expected. If it is stuck clear, a committed pair never appears. The wide-screen payload is checked by writing a lone first byte and seeing that the old pair still comes out on the next wide-screen line. Write/line collisions are driven in the same cycle. A wrong priority between commit and consume then shows up on that line, or one frame later.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] NULL_CODE = 8'h80;

  // register addresses; the field meaning of the control word is fixed
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_CAP_B0 = 1;
  localparam int ADDR_CAP_B1 = 2;
  localparam int ADDR_WSS_B0 = 3;
  localparam int ADDR_WSS_B1 = 4;

  localparam int CTRL_CAP_BIT = 0;
  localparam int CTRL_WSS_BIT = 1;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic capStage;
    logic capCommit;
    logic wssStage;
    logic wssCommit;
    logic capSlot;
    logic wssSlot;
  } vbiStrobes_t;
endpackage

// File: rtl/vbi_ctrl.sv
module vbi_ctrl
  import vbi_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int LINE_W    = 10,
  parameter int CAP_LINE  = 21,
  parameter int WSS_LINE  = 23,
  parameter bit CAP_FIELD = 1'b0,
  parameter bit WSS_FIELD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              lineStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldId,
  output vbiStrobes_t       strb,
  output logic              capEnable,
  output logic              wssEnable
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CB0  = ADDR_W'(ADDR_CAP_B0);
  localparam logic [ADDR_W-1:0] A_CB1  = ADDR_W'(ADDR_CAP_B1);
  localparam logic [ADDR_W-1:0] A_WB0  = ADDR_W'(ADDR_WSS_B0);
  localparam logic [ADDR_W-1:0] A_WB1  = ADDR_W'(ADDR_WSS_B1);
  localparam logic [LINE_W-1:0] L_CAP  = LINE_W'(CAP_LINE);
  localparam logic [LINE_W-1:0] L_WSS  = LINE_W'(WSS_LINE);

  logic ctrlHit;
  assign ctrlHit = regWrEn && (regAddr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capEnable <= 1'b0;
      wssEnable <= 1'b0;
    end else if (ctrlHit) begin
      capEnable <= regWrData[CTRL_CAP_BIT];
      wssEnable <= regWrData[CTRL_WSS_BIT];
    end
  end

  always_comb begin
    strb.capStage  = regWrEn && (regAddr == A_CB0);
    strb.capCommit = regWrEn && (regAddr == A_CB1);
    strb.wssStage  = regWrEn && (regAddr == A_WB0);
    strb.wssCommit = regWrEn && (regAddr == A_WB1);
    strb.capSlot   = lineStart && capEnable && (lineNum == L_CAP) && (fieldId == CAP_FIELD);
    strb.wssSlot   = lineStart && wssEnable && (lineNum == L_WSS) && (fieldId == WSS_FIELD);
  end

  // enables only move on a control write
  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlHit |=> ($stable(capEnable) && $stable(wssEnable)));
endmodule

// File: rtl/vbi_data.sv
module vbi_data
  import vbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vbiStrobes_t       strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              outValid,
  output logic              outService,
  output logic [BYTE_W-1:0] outByte0,
  output logic [BYTE_W-1:0] outByte1
);
  localparam int PAIR_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] capStageQ, wssStageQ;
  logic [PAIR_W-1:0] capPayQ, wssPayQ;
  logic              capFresh;

  // staging and commit of both services
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capStageQ <= '0;
      wssStageQ <= '0;
      capPayQ   <= '0;
      wssPayQ   <= '0;
    end else begin
      if (strb.capStage)  capStageQ <= wrData;
      if (strb.wssStage)  wssStageQ <= wrData;
      if (strb.capCommit) capPayQ   <= {capStageQ, wrData};
      if (strb.wssCommit) wssPayQ   <= {wssStageQ, wrData};
    end
  end

  // a commit on the emission cycle wins, so it survives for next frame
  always_ff @(posedge clk) begin
    if (!rstN)               capFresh <= 1'b0;
    else if (strb.capCommit) capFresh <= 1'b1;
    else if (strb.capSlot)   capFresh <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outService <= 1'b0;
      outByte0   <= '0;
      outByte1   <= '0;
    end else begin
      outValid <= strb.capSlot || strb.wssSlot;
      if (strb.capSlot) begin
        outService <= 1'b0;
        {outByte0, outByte1} <= capFresh ? capPayQ : {NULL_CODE, NULL_CODE};
      end else if (strb.wssSlot) begin
        outService <= 1'b1;
        {outByte0, outByte1} <= wssPayQ;
      end
    end
  end

  assert_consumed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capSlot && !strb.capCommit) |=> !capFresh);
  assert_commit_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capCommit |=> capFresh);
  assert_stage_quiet_wss_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wssCommit) |=> $stable(wssPayQ));
  assert_stage_quiet_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capCommit) |=> $stable(capPayQ));
endmodule

// File: rtl/vbi_line_inserter.sv
module vbi_line_inserter
  import vbi_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int LINE_W    = 10,
  parameter int CAP_LINE  = 21,
  parameter int WSS_LINE  = 23,
  parameter bit CAP_FIELD = 1'b0,
  parameter bit WSS_FIELD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              lineStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldId,
  output logic              outValid,
  output logic              outService,
  output logic [7:0]        outByte0,
  output logic [7:0]        outByte1
);
  vbiStrobes_t strb;
  logic        capEnable, wssEnable;

  vbi_ctrl #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CAP_LINE(CAP_LINE), .WSS_LINE(WSS_LINE),
    .CAP_FIELD(CAP_FIELD), .WSS_FIELD(WSS_FIELD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lineStart(lineStart), .lineNum(lineNum),
    .fieldId(fieldId), .strb(strb), .capEnable(capEnable), .wssEnable(wssEnable)
  );

  vbi_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .outValid(outValid), .outService(outService),
    .outByte0(outByte0), .outByte1(outByte1)
  );

  assert_valid_follows_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(lineStart));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!capEnable && !wssEnable) |=> !outValid);
endmodule

// File: tb/tb_vbi_line_inserter.sv
`timescale 1ns/1ps
module tb_vbi_line_inserter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       lineStart = 1'b0;
  logic [9:0] lineNum = '0;
  logic       fieldId = 1'b0;
  logic       outValid, outService;
  logic [7:0] outByte0, outByte1;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vbi_line_inserter dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lineStart(lineStart), .lineNum(lineNum),
    .fieldId(fieldId), .outValid(outValid), .outService(outService),
    .outByte0(outByte0), .outByte1(outByte1)
  );

  // {isLine, addrOrLine[9:0], data[7:0], field, expV, expS, b0[7:0], b1[7:0], req[3:0]}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 10'd0,  8'h03, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2}, // R2 enable both
    {1'b1, 10'd21, 8'h00, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 4'd4}, // R4 nothing written
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 4'd1}, // R1 reset wss pair
    {1'b0, 10'd1,  8'h14, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2},
    {1'b0, 10'd2,  8'h2C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2},
    {1'b1, 10'd21, 8'h00, 1'b0, 1'b1, 1'b0, 8'h14, 8'h2C, 4'd3}, // R3 fresh pair
    {1'b1, 10'd21, 8'h00, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 4'd4}, // R4 null after send
    {1'b0, 10'd3,  8'h31, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2},
    {1'b0, 10'd4,  8'h06, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2},
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b1, 1'b1, 8'h31, 8'h06, 4'd5}, // R5 wss pair
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b1, 1'b1, 8'h31, 8'h06, 4'd5}, // R5 repeated
    {1'b0, 10'd3,  8'h77, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd6},
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b1, 1'b1, 8'h31, 8'h06, 4'd6}, // R6 lone first byte
    {1'b0, 10'd1,  8'h55, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd6},
    {1'b1, 10'd21, 8'h00, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 4'd6}, // R6 caption stays null
    {1'b1, 10'd21, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'd9}, // R9 second field
    {1'b1, 10'd22, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd9}, // R9 other line
    {1'b0, 10'd4,  8'h0F, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd6},
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b1, 1'b1, 8'h77, 8'h0F, 4'd6}, // R6 staged byte used
    {1'b0, 10'd0,  8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd8},
    {1'b1, 10'd23, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd8}, // R8 wss disabled
    {1'b0, 10'd2,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd8},
    {1'b0, 10'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd8},
    {1'b1, 10'd21, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd8}  // R8 caption disabled
  };

  task automatic checkOut(input int req, input logic eV, input logic eS,
                          input logic [7:0] e0, input logic [7:0] e1);
    nChecks++;
    if (eV == 1'b0) begin
      if (outValid !== 1'b0) begin
        nErrors++;
        $display("FAIL R%0d: outValid=%b expected 0", req, outValid);
      end
    end else if ({outValid, outService, outByte0, outByte1} !== {1'b1, eS, e0, e1}) begin
      nErrors++;
      $display("FAIL R%0d: valid=%b svc=%b bytes=%h,%h expected valid=1 svc=%b bytes=%h,%h",
               req, outValid, outService, outByte0, outByte1, eS, e0, e1);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // line pulse; outputs are registered at the edge in between, sampled at next negedge
  task automatic doLine(input logic [9:0] n, input logic f);
    @(negedge clk);
    lineStart = 1'b1; lineNum = n; fieldId = f;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  // second-byte write in the very cycle of the target line start
  task automatic doLineWithWrite(input logic [9:0] n, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    lineStart = 1'b1; lineNum = n; fieldId = 1'b0;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    lineStart = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nErrors++; nChecks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1'b0, 1'b0, 8'h00, 8'h00);          // R1 idle after reset
    doLine(10'd21, 1'b0);
    checkOut(1, 1'b0, 1'b0, 8'h00, 8'h00);          // R1 services start disabled

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) begin
        doLine(VEC[i][40:31], VEC[i][22]);
        checkOut(int'(VEC[i][3:0]), VEC[i][21], VEC[i][20], VEC[i][19:12], VEC[i][11:4]);
      end else begin
        doWrite(VEC[i][33:31], VEC[i][30:23]);
      end
    end

    // R8: pending caption pair survived the disabled line
    doWrite(3'd0, 8'h03);
    doLine(10'd21, 1'b0);
    checkOut(8, 1'b1, 1'b0, 8'h55, 8'h00);

    // R7: caption commit on the line-start cycle sends null now, the pair next frame
    doWrite(3'd1, 8'hA1);
    doLineWithWrite(10'd21, 3'd2, 8'hB2);
    checkOut(7, 1'b1, 1'b0, 8'h80, 8'h80);
    doLine(10'd21, 1'b0);
    checkOut(7, 1'b1, 1'b0, 8'hA1, 8'hB2);

    // R7: wide-screen commit on the line-start cycle keeps the old pair this line
    doWrite(3'd3, 8'h12);
    doLineWithWrite(10'd23, 3'd4, 8'h34);
    checkOut(7, 1'b1, 1'b1, 8'h77, 8'h0F);
    doLine(10'd23, 1'b0);
    checkOut(7, 1'b1, 1'b1, 8'h12, 8'h34);

    // R3: valid lasts a single cycle
    doLine(10'd23, 1'b0);
    @(negedge clk);
    checkOut(3, 1'b0, 1'b0, 8'h00, 8'h00);

    // R1: reset mid-run clears enables and payloads
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doWrite(3'd0, 8'h02);
    doLine(10'd23, 1'b0);
    checkOut(1, 1'b1, 1'b1, 8'h00, 8'h00);

    finishRun();
  end
endmodule